// File: doc/BRIEF.md
# Pairwise Single-Precision Vector Adder

This unit executes one instruction: a floating-point add that works on adjacent element pairs. It receives a 32-bit instruction word and two source vectors of up to 128 bits. It decodes the word and checks that it matches the three-register pairwise vector add. It then places the second source above the first to form a double-width vector. Each adjacent pair of 32-bit elements in that vector is summed into one destination element. Only binary32 elements are handled, and every sum is rounded to nearest with ties to even. Subnormal values are fully supported.

Exceptions are never trapped. The unit keeps four sticky status bits, and only reset clears them. Any word that does not match the pattern, or that selects a precision other than single, is reported as undefined. In that case no result is produced and the status bits are left as they were. Operations are accepted on a valid strobe and leave the unit exactly two cycles later, one operation per cycle if needed.

Top module: `fpaddp_unit`

## Requirements
- R1: An instruction word is legal only if `(insn & 32'hBFA0FC00) == 32'h2E20D400`. Any other word produces a result with `out_undef` = 1 and `out_data` = 0, and leaves the four status flags unchanged.
- R2: A word matching that pattern with bit 22 set (double precision) is also reported as undefined, whatever bit 30 holds, with zero data and unchanged flags.
- R3: For a legal word, lane e of `out_data` (bits 32e+31:32e) is the sum of elements 2e and 2e+1 of the joined vector. In that vector the second source sits above the first. With bit 30 = 1, lanes 0 and 1 come from `src_n` element pairs (0,1) and (2,3), and lanes 2 and 3 come from `src_m` in the same way. With bit 30 = 0, lane 0 is `src_n[31:0]` + `src_n[63:32]`, lane 1 is `src_m[31:0]` + `src_m[63:32]`, and `out_data[127:64]` is zero.
- R4: `out_rd`, `out_rn` and `out_rm` carry instruction bits 4:0, 9:5 and 20:16 of the word issued two cycles before.
- R5: Each sum is the exact sum rounded to nearest, ties to even. Subnormal operands and results use gradual underflow.
- R6: Any NaN operand gives 32'h7FC00000. A signaling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear) raises the invalid flag, and a quiet NaN does not. Infinity plus infinity of opposite sign also gives 32'h7FC00000 and raises invalid. Infinity plus a finite value returns that infinity.
- R7: A rounded result beyond the largest finite value becomes a signed infinity and raises both overflow and inexact.
- R8: Any rounding raises inexact. Underflow is raised only for a result that is tiny before rounding and inexact. Because subnormal sums of binary32 values are always exact, no addition raises underflow.
- R9: An exact zero sum of operands with opposite sign is +0. The sum of -0 and -0 is -0.
- R10: The flags `flag_invalid`, `flag_overflow`, `flag_underflow` and `flag_inexact` are the OR over all active lanes and all legal operations since reset. Once set, they stay set.
- R11: `out_valid` goes high exactly two clock edges after the edge that samples `in_valid`, for one cycle per operation. Operations may be issued on consecutive cycles.
- R12: A synchronous active-high `rst` clears `out_valid`, `out_undef`, `out_data`, the register indices and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| insn | input | 32 | Instruction word |
| src_n | input | 128 | First source vector (lower half of the joined vector) |
| src_m | input | 128 | Second source vector (upper half of the joined vector) |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_undef | output | 1 | Word was illegal or unsupported |
| out_data | output | 128 | Destination vector |
| out_rd | output | 5 | Destination register index |
| out_rn | output | 5 | First source register index |
| out_rm | output | 5 | Second source register index |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_overflow | output | 1 | Sticky overflow flag |
| flag_underflow | output | 1 | Sticky underflow flag |
| flag_inexact | output | 1 | Sticky inexact flag |

## Verification
The assertions assume that `in_valid` and `insn` hold known values on every sampled edge after reset, and that reset is held for at least one edge before the first operation. They also assume that a strobe raised during reset is not expected to produce a result. The bench meets these conditions by driving every input on the falling edge from a defined idle state and holding reset for several cycles. Operands come from a seeded generator that mixes zeros, infinities, both kinds of NaN, subnormals and values near the overflow limit, so that every flag and special path appears in both lane layouts.

// File: rtl/fpaddp_pkg.sv
package fpaddp_pkg;

    localparam int ELEM_W = 32;
    localparam int IDX_W  = 5;

    localparam logic [31:0] OPC_BASE = 32'h2E20D400;
    localparam logic [31:0] OPC_MASK = 32'hBFA0FC00;
    localparam int          BIT_WIDE = 30;
    localparam int          BIT_DBL  = 22;

    localparam logic [31:0] QNAN_DEF = 32'h7FC00000;

    typedef struct packed {
        logic nv;
        logic of;
        logic uf;
        logic nx;
    } fp_flags_t;

    typedef struct packed {
        logic             matched;
        logic             legal;
        logic             wide;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rm;
    } op_fields_t;

    // Number of zero bits above the highest set bit of a 27-bit value.
    function automatic logic [4:0] lead_zeros27(input logic [26:0] v);
        logic [4:0] n;
        n = 5'd27;
        for (int i = 0; i < 27; i++) begin
            if (v[i]) n = 5'(26 - i);
        end
        return n;
    endfunction

endpackage

// File: rtl/fpp_decode.sv
module fpp_decode
    import fpaddp_pkg::*;
(
    input  logic [31:0] insn,
    output op_fields_t  fields
);
    always_comb begin
        fields.matched = ((insn & OPC_MASK) == OPC_BASE);
        fields.legal   = fields.matched && !insn[BIT_DBL];
        fields.wide    = insn[BIT_WIDE];
        fields.rd      = insn[4:0];
        fields.rn      = insn[9:5];
        fields.rm      = insn[20:16];
    end
endmodule

// File: rtl/fpp_fadd32.sv
module fpp_fadd32
    import fpaddp_pkg::*;
(
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    output logic [31:0] sum,
    output fp_flags_t   flags
);
    logic        a_nan, b_nan, a_snan, b_snan, a_inf, b_inf;
    logic [31:0] big, sml;
    logic [8:0]  e_big, e_sml, e_gap, e_m1;
    logic [4:0]  gap_c, lz, lsh;
    logic [23:0] sig_big, sig_sml;
    logic [52:0] shifted;
    logic [26:0] al_sml, norm;
    logic [27:0] raw;
    logic [9:0]  e_res;
    logic [24:0] rmant;
    logic        up, tiny, inexact;
    logic [7:0]  e_field;

    always_comb begin
        a_nan  = (&op_a[30:23]) && (|op_a[22:0]);
        b_nan  = (&op_b[30:23]) && (|op_b[22:0]);
        a_snan = a_nan && !op_a[22];
        b_snan = b_nan && !op_b[22];
        a_inf  = (&op_a[30:23]) && !(|op_a[22:0]);
        b_inf  = (&op_b[30:23]) && !(|op_b[22:0]);

        // order by magnitude so the subtraction never goes negative
        if (op_b[30:0] > op_a[30:0]) begin
            big = op_b;
            sml = op_a;
        end else begin
            big = op_a;
            sml = op_b;
        end

        e_big   = (big[30:23] == 8'd0) ? 9'd1 : {1'b0, big[30:23]};
        e_sml   = (sml[30:23] == 8'd0) ? 9'd1 : {1'b0, sml[30:23]};
        sig_big = {|big[30:23], big[22:0]};
        sig_sml = {|sml[30:23], sml[22:0]};
        e_gap   = e_big - e_sml;
        gap_c   = (e_gap > 9'd26) ? 5'd26 : e_gap[4:0];

        // align the smaller operand: 24 bits + guard, round, sticky
        shifted = {sig_sml, 29'd0} >> gap_c;
        al_sml  = {shifted[52:27], |shifted[26:0]};

        if (big[31] ^ sml[31])
            raw = {1'b0, sig_big, 3'b000} - {1'b0, al_sml};
        else
            raw = {1'b0, sig_big, 3'b000} + {1'b0, al_sml};

        lz   = lead_zeros27(raw[26:0]);
        e_m1 = e_big - 9'd1;
        if (raw[27]) begin
            lsh   = 5'd0;
            norm  = {raw[27:2], raw[1] | raw[0]};
            e_res = {1'b0, e_big} + 10'd1;
        end else begin
            // never normalise below the smallest normal exponent
            lsh   = ({4'd0, lz} > e_m1) ? e_m1[4:0] : lz;
            norm  = raw[26:0] << lsh;
            e_res = {1'b0, e_big} - {5'd0, lsh};
        end

        tiny    = !norm[26];
        inexact = |norm[2:0];
        up      = norm[2] && (norm[1] || norm[0] || norm[3]);
        rmant   = {1'b0, norm[26:3]} + {24'd0, up};
        if (rmant[24]) begin
            rmant = {1'b0, rmant[24:1]};
            e_res = e_res + 10'd1;
        end
        e_field = rmant[23] ? e_res[7:0] : 8'd0;

        sum   = {big[31], e_field, rmant[22:0]};
        flags = '0;
        if (a_nan || b_nan) begin
            sum      = QNAN_DEF;
            flags.nv = a_snan || b_snan;
        end else if (a_inf && b_inf && (op_a[31] != op_b[31])) begin
            sum      = QNAN_DEF;
            flags.nv = 1'b1;
        end else if (a_inf) begin
            sum = op_a;
        end else if (b_inf) begin
            sum = op_b;
        end else if (raw == 28'd0) begin
            sum = {op_a[31] & op_b[31], 31'd0};
        end else if (rmant[23] && (e_res >= 10'd255)) begin
            sum      = {big[31], 8'hFF, 23'd0};
            flags.of = 1'b1;
            flags.nx = 1'b1;
        end else begin
            flags.nx = inexact;
            flags.uf = tiny && inexact;
        end
    end
endmodule

// File: rtl/fpaddp_unit.sv
module fpaddp_unit
    import fpaddp_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      insn,
    input  logic [VEC_W-1:0] src_n,
    input  logic [VEC_W-1:0] src_m,
    output logic             out_valid,
    output logic             out_undef,
    output logic [VEC_W-1:0] out_data,
    output logic [IDX_W-1:0] out_rd,
    output logic [IDX_W-1:0] out_rn,
    output logic [IDX_W-1:0] out_rm,
    output logic             flag_invalid,
    output logic             flag_overflow,
    output logic             flag_underflow,
    output logic             flag_inexact
);
    localparam int LANES = VEC_W / ELEM_W;
    localparam int HALF  = LANES / 2;
    localparam int QTR   = HALF / 2;

    op_fields_t dec;
    fpp_decode u_dec (.insn(insn), .fields(dec));

    logic [LANES-1:0][ELEM_W-1:0] n_el, m_el, lane_a, lane_b, lane_sum;
    logic [LANES-1:0]             lane_on;
    fp_flags_t                    lane_flg [LANES];

    assign n_el = src_n;
    assign m_el = src_m;

    generate
        for (genvar e = 0; e < LANES; e++) begin : g_lane
            localparam bit W_FROM_M = (e >= HALF);
            localparam int W_PAIR   = W_FROM_M ? e - HALF : e;
            localparam bit N_FROM_M = (e >= QTR);
            localparam int N_RAW    = N_FROM_M ? e - QTR : e;
            localparam int N_PAIR   = (N_RAW < QTR) ? N_RAW : 0;

            always_comb begin
                if (dec.wide) begin
                    lane_a[e] = W_FROM_M ? m_el[2*W_PAIR]   : n_el[2*W_PAIR];
                    lane_b[e] = W_FROM_M ? m_el[2*W_PAIR+1] : n_el[2*W_PAIR+1];
                end else begin
                    lane_a[e] = N_FROM_M ? m_el[2*N_PAIR]   : n_el[2*N_PAIR];
                    lane_b[e] = N_FROM_M ? m_el[2*N_PAIR+1] : n_el[2*N_PAIR+1];
                end
            end

            assign lane_on[e] = dec.wide || (e < HALF);

            fpp_fadd32 u_add (
                .op_a (lane_a[e]),
                .op_b (lane_b[e]),
                .sum  (lane_sum[e]),
                .flags(lane_flg[e])
            );
        end
    endgenerate

    fp_flags_t                    merged;
    logic [LANES-1:0][ELEM_W-1:0] masked;

    always_comb begin
        merged = '0;
        for (int e = 0; e < LANES; e++) begin
            masked[e] = (lane_on[e] && dec.legal) ? lane_sum[e] : '0;
            if (lane_on[e] && dec.legal) merged = fp_flags_t'(merged | lane_flg[e]);
        end
    end

    // stage 1: lane results
    logic             s1_valid, s1_undef, s1_wide;
    logic [VEC_W-1:0] s1_data;
    fp_flags_t        s1_flags;
    logic [IDX_W-1:0] s1_rd, s1_rn, s1_rm;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_undef <= 1'b0;
            s1_wide  <= 1'b0;
            s1_data  <= '0;
            s1_flags <= '0;
            s1_rd    <= '0;
            s1_rn    <= '0;
            s1_rm    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_undef <= !dec.legal;
                s1_wide  <= dec.wide;
                s1_data  <= masked;
                s1_flags <= merged;
                s1_rd    <= dec.rd;
                s1_rn    <= dec.rn;
                s1_rm    <= dec.rm;
            end
        end
    end

    // stage 2: outputs and sticky status
    fp_flags_t sticky;
    logic      o_wide;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_undef <= 1'b0;
            out_data  <= '0;
            out_rd    <= '0;
            out_rn    <= '0;
            out_rm    <= '0;
            o_wide    <= 1'b0;
            sticky    <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_undef <= s1_undef;
                out_data  <= s1_undef ? '0 : s1_data;
                out_rd    <= s1_rd;
                out_rn    <= s1_rn;
                out_rm    <= s1_rm;
                o_wide    <= s1_wide;
                if (!s1_undef) sticky <= fp_flags_t'(sticky | s1_flags);
            end
        end
    end

    assign flag_invalid   = sticky.nv;
    assign flag_overflow  = sticky.of;
    assign flag_underflow = sticky.uf;
    assign flag_inexact   = sticky.nx;

    a_r11_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    a_r1_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_undef) |-> (out_data == '0));

    a_r3_narrow_upper: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_undef && !o_wide) |-> (out_data[VEC_W-1:VEC_W/2] == '0));

    a_r10_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (sticky != '0) |=> ((sticky & $past(sticky)) == $past(sticky)));

    a_r2_undef_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_undef) |-> (sticky == $past(sticky)));

    a_r7_ovf_inexact: assert property (@(posedge clk) disable iff (rst)
        s1_valid |-> (!s1_flags.of || s1_flags.nx));

    a_r8_uf_inexact: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_flags.uf) |-> s1_flags.nx);

endmodule

// File: tb/fpaddp_unit_test.sv
module fpaddp_unit_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  insn;
    logic [127:0] src_n, src_m;
    logic         out_valid, out_undef;
    logic [127:0] out_data;
    logic [4:0]   out_rd, out_rn, out_rm;
    logic         flag_invalid, flag_overflow, flag_underflow, flag_inexact;

    always #4 clk = ~clk;

    fpaddp_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .src_n(src_n), .src_m(src_m),
        .out_valid(out_valid), .out_undef(out_undef), .out_data(out_data),
        .out_rd(out_rd), .out_rn(out_rn), .out_rm(out_rm),
        .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
        .flag_underflow(flag_underflow), .flag_inexact(flag_inexact)
    );

    int         errs = 0;
    int         checks = 0;
    logic [3:0] exp_stk;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] mk_insn(input logic q, input logic sz,
                                            input logic [4:0] rm, input logic [4:0] rn,
                                            input logic [4:0] rd);
        return 32'h2E20D400 | ({31'd0, q} << 30) | ({31'd0, sz} << 22)
             | ({27'd0, rm} << 16) | ({27'd0, rn} << 5) | {27'd0, rd};
    endfunction

    // magnitude as an integer count of 2^-149
    function automatic logic [299:0] mag_of(input logic [31:0] x);
        logic [299:0] t;
        t = {276'd0, (x[30:23] != 8'd0), x[22:0]};
        if (x[30:23] != 8'd0) t = t << (x[30:23] - 8'd1);
        return t;
    endfunction

    // returns {nv, of, uf, nx, sum}
    function automatic logic [35:0] ref_add(input logic [31:0] a, input logic [31:0] b);
        logic a_nan, b_nan, a_inf, b_inf, sg, nx;
        logic [299:0] ma, mb, mag, keep, rem, half;
        int p, sh, ev;
        a_nan = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        b_nan = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        a_inf = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        b_inf = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        if (a_nan || b_nan)
            return {((a_nan && !a[22]) || (b_nan && !b[22])), 3'b000, 32'h7FC00000};
        if (a_inf && b_inf && (a[31] != b[31])) return {4'b1000, 32'h7FC00000};
        if (a_inf) return {4'b0000, a};
        if (b_inf) return {4'b0000, b};
        ma = mag_of(a);
        mb = mag_of(b);
        if (a[31] == b[31]) begin
            mag = ma + mb; sg = a[31];
        end else if (ma >= mb) begin
            mag = ma - mb; sg = a[31];
        end else begin
            mag = mb - ma; sg = b[31];
        end
        if (mag == 0) return {4'b0000, a[31] & b[31], 31'd0};
        p = 0;
        for (int i = 0; i < 300; i++) if (mag[i]) p = i;
        if (p <= 23) return {4'b0000, sg, mag[30:0]};
        sh   = p - 23;
        keep = mag >> sh;
        rem  = mag - (keep << sh);
        half = 300'd1 << (sh - 1);
        nx   = (rem != 0);
        if ((rem > half) || ((rem == half) && keep[0])) keep = keep + 1;
        ev = sh + 1;
        if (keep[24]) begin
            keep = keep >> 1;
            ev++;
        end
        if (ev >= 255) return {4'b0101, sg, 8'hFF, 23'd0};
        return {3'b000, nx, sg, ev[7:0], keep[22:0]};
    endfunction

    task automatic expect_op(input logic [31:0] w, input logic [127:0] n, input logic [127:0] m,
                             output logic [127:0] edata, output logic eundef,
                             output logic [3:0] eflags);
        logic [255:0] cat;
        logic [35:0]  r;
        int           k;
        edata  = '0;
        eflags = '0;
        eundef = !(((w & 32'hBFA0FC00) == 32'h2E20D400) && !w[22]);
        if (!eundef) begin
            cat = w[30] ? {m, n} : {128'd0, m[63:0], n[63:0]};
            k   = w[30] ? 4 : 2;
            for (int e = 0; e < k; e++) begin
                r = ref_add(cat[64*e +: 32], cat[64*e+32 +: 32]);
                edata[32*e +: 32] = r[31:0];
                eflags = eflags | r[35:32];
            end
        end
    endtask

    task automatic check_out(input string tag, input logic [31:0] w,
                             input logic [127:0] edata, input logic eundef);
        chk("R11 out_valid", {127'd0, out_valid}, 128'd1);
        chk($sformatf("%s undef", tag), {127'd0, out_undef}, {127'd0, eundef});
        chk($sformatf("%s data", tag), out_data, edata);
        chk("R10 flags", {124'd0, flag_invalid, flag_overflow, flag_underflow, flag_inexact},
            {124'd0, exp_stk});
        chk("R4 indices", {113'd0, out_rd, out_rn, out_rm}, {113'd0, w[4:0], w[9:5], w[20:16]});
    endtask

    task automatic run_op(input string tag, input logic [31:0] w,
                          input logic [127:0] n, input logic [127:0] m);
        logic [127:0] ed;
        logic         eu;
        logic [3:0]   ef;
        expect_op(w, n, m, ed, eu, ef);
        if (!eu) exp_stk = exp_stk | ef;
        @(negedge clk);
        in_valid = 1'b1; insn = w; src_n = n; src_m = m;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; insn = $urandom; src_n = {4{$urandom}}; src_m = {4{$urandom}};
        @(posedge clk);
        #2;
        check_out(tag, w, ed, eu);
        @(posedge clk);
        #2;
        chk("R11 single pulse", {127'd0, out_valid}, 128'd0);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_stk = '0;
    endtask

    function automatic logic [31:0] rand_f();
        logic s;
        int   c;
        s = 1'($urandom);
        c = $urandom % 20;
        case (c)
            0:       return {s, 31'd0};
            1:       return {s, 8'hFF, 23'd0};
            2:       return {s, 8'hFF, 1'b0, 21'($urandom), 1'b1};
            3:       return {s, 8'hFF, 1'b1, 22'($urandom)};
            4, 5:    return {s, 8'd0, 23'($urandom)};
            6, 7:    return {s, 8'(250 + $urandom % 5), 23'($urandom)};
            8:       return {s, 8'd1, 23'($urandom)};
            default: return {s, 8'(120 + $urandom % 16), 23'($urandom)};
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        errs++;
        checks++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [127:0] ea, eb;
        logic         ua, ub;
        logic [3:0]   fa, fb;
        logic [31:0]  wa, wb, w;
        logic [127:0] rn_v, rm_v;

        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; insn = '0; src_n = '0; src_m = '0;
        exp_stk = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R12 reset state
        chk("R12 out_valid", {127'd0, out_valid}, 128'd0);
        chk("R12 out_data", out_data, 128'd0);
        chk("R12 flags", {124'd0, flag_invalid, flag_overflow, flag_underflow, flag_inexact}, 128'd0);

        // R3 lane order, wide form: 1+2, 3+4, 5+6, 7+8
        run_op("R3", mk_insn(1'b1, 1'b0, 5'd2, 5'd1, 5'd0),
               {32'h40800000, 32'h40400000, 32'h40000000, 32'h3F800000},
               {32'h41000000, 32'h40E00000, 32'h40C00000, 32'h40A00000});
        chk("R3 lane3 value", {96'd0, out_data[127:96]}, {96'd0, 32'h41700000});
        // R3 narrow form ignores the upper halves
        run_op("R3", mk_insn(1'b0, 1'b0, 5'd17, 5'd9, 5'd31),
               {32'h4B000001, 32'hC2F00000, 32'h40000000, 32'h3F800000},
               {32'h7F800001, 32'h3F800000, 32'h40400000, 32'h40A00000});

        // R5 and R8: ties, subnormals, inexact flag
        apply_reset();
        run_op("R5", mk_insn(1'b1, 1'b0, 5'd3, 5'd4, 5'd5),
               {32'h007FFFFF, 32'h00000001, 32'h33800000, 32'h3F800000},
               {32'hB3800000, 32'h3F800001, 32'h00000001, 32'h00000001});
        chk("R5 tie to even", {96'd0, out_data[31:0]}, {96'd0, 32'h3F800000});
        chk("R5 subnormal to normal", {96'd0, out_data[63:32]}, {96'd0, 32'h00800000});
        chk("R8 inexact", {127'd0, flag_inexact}, 128'd1);
        chk("R8 underflow", {127'd0, flag_underflow}, 128'd0);

        // R9 signed zeros
        run_op("R9", mk_insn(1'b1, 1'b0, 5'd6, 5'd7, 5'd8),
               {32'h80000000, 32'h80000000, 32'h80000000, 32'h00000000},
               {32'h00000000, 32'h00000000, 32'hBFC00000, 32'h3FC00000});
        chk("R9 minus zero", {96'd0, out_data[63:32]}, {96'd0, 32'h80000000});

        // R6 quiet NaN alone raises nothing
        apply_reset();
        run_op("R6", mk_insn(1'b1, 1'b0, 5'd1, 5'd1, 5'd1),
               {32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h7FC12345},
               {32'h3F800000, 32'h7F800000, 32'hFFC00001, 32'h40000000});
        chk("R6 qnan no invalid", {127'd0, flag_invalid}, 128'd0);
        run_op("R6", mk_insn(1'b1, 1'b0, 5'd2, 5'd2, 5'd2),
               {32'h00000000, 32'h7F800001, 32'hFF800000, 32'h7F800000},
               {32'h3F800000, 32'hFF800000, 32'h00000000, 32'h00000000});
        chk("R6 invalid", {127'd0, flag_invalid}, 128'd1);

        // R7 overflow both signs
        run_op("R7", mk_insn(1'b1, 1'b0, 5'd0, 5'd0, 5'd0),
               {32'hFF7FFFFF, 32'hFF7FFFFF, 32'h7F7FFFFF, 32'h7F7FFFFF},
               {32'h7F000000, 32'h7F7FFFFF, 32'h3F800000, 32'h3F800000});
        chk("R7 overflow flag", {127'd0, flag_overflow}, 128'd1);

        // R1 and R2: illegal and double-precision words
        apply_reset();
        run_op("R1", mk_insn(1'b1, 1'b0, 5'd1, 5'd2, 5'd3) ^ 32'h00000800,
               {4{32'h7F7FFFFF}}, {4{32'h7F800001}});
        run_op("R2", mk_insn(1'b1, 1'b1, 5'd1, 5'd2, 5'd3),
               {4{32'h7F7FFFFF}}, {4{32'h7F800001}});
        run_op("R2", mk_insn(1'b0, 1'b1, 5'd4, 5'd5, 5'd6),
               {4{32'h7F7FFFFF}}, {4{32'h3F800001}});
        chk("R2 flags untouched", {124'd0, flag_invalid, flag_overflow, flag_underflow, flag_inexact},
            128'd0);

        // R11 back-to-back issue
        wa = mk_insn(1'b1, 1'b0, 5'd10, 5'd11, 5'd12);
        wb = mk_insn(1'b0, 1'b0, 5'd13, 5'd14, 5'd15);
        rn_v = {rand_f(), rand_f(), rand_f(), rand_f()};
        rm_v = {rand_f(), rand_f(), rand_f(), rand_f()};
        expect_op(wa, rn_v, rm_v, ea, ua, fa);
        expect_op(wb, rm_v, rn_v, eb, ub, fb);
        @(negedge clk);
        in_valid = 1'b1; insn = wa; src_n = rn_v; src_m = rm_v;
        @(posedge clk);
        @(negedge clk);
        insn = wb; src_n = rm_v; src_m = rn_v;
        @(posedge clk);
        #2;
        exp_stk = exp_stk | fa;
        check_out("R11 first", wa, ea, ua);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #2;
        exp_stk = exp_stk | fb;
        check_out("R11 second", wb, eb, ub);

        // R12 reset in mid run clears sticky flags
        apply_reset();
        #1;
        chk("R12 flags cleared", {124'd0, flag_invalid, flag_overflow, flag_underflow, flag_inexact},
            128'd0);

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            w = mk_insn(1'($urandom), ($urandom % 8) == 0, 5'($urandom), 5'($urandom),
                        5'($urandom));
            if (($urandom % 12) == 0) w = w ^ (32'd1 << (10 + $urandom % 6));
            if ((i % 100) == 99) apply_reset();
            run_op("R5 random", w,
                   {rand_f(), rand_f(), rand_f(), rand_f()},
                   {rand_f(), rand_f(), rand_f(), rand_f()});
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule